// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing fields of a memory-reference instruction into the address of the operand. It takes a two-bit mode, a 9-bit displacement, an optional second instruction word, the current index register and the instruction counter. A one-cycle `start` pulse launches a calculation. The result appears on `ea` together with a one-cycle `done` pulse.

There are four modes. Absolute addressing takes the address either from the displacement or from the full second word. Index-based addressing adds the displacement to the index register. Counter-relative addressing adds a signed displacement to the instruction counter. The instruction counter input carries the next-instruction address that was latched when the current instruction began. Pointer-based addressing reads one word from memory through a request/acknowledge port, at a fixed offset of 512 above the displacement, and returns that word as the operand address.

The arithmetic modes finish one cycle after `start`. The pointer mode finishes one cycle after the memory acknowledge. While a pointer read is outstanding, the block refuses new work.

Top module: `operand_addr_gen`

## Requirements
- R1: Synchronous active-high reset clears `done`, `mem_req`, `mem_addr` and `ea` to zero.
- R2: With `mode`=00 (absolute) and `use_ext`=0, the cycle after an accepted `start` has `done`=1 and `ea` equal to the zero-extended 9-bit displacement, so words 0 to 511 are all reachable.
- R3: With `mode`=00 and `use_ext`=1, the cycle after an accepted `start` has `done`=1 and `ea` equal to `ext_word`, whatever the displacement is.
- R4: With `mode`=01 (pointer), the cycle after an accepted `start` has `mem_req`=1 and `mem_addr` equal to the zero-extended displacement plus 512. `done` stays 0, and `mem_req` and `mem_addr` hold steady until `mem_ack` is sampled high.
- R5: In the cycle after `mem_ack` is sampled high with `mem_req`=1, `done` is 1, `ea` equals the `mem_rdata` sampled with the acknowledge, and `mem_req` is 0.
- R6: With `mode`=10 (index-based), the cycle after an accepted `start` has `done`=1 and `ea` = (`idx_val` + zero-extended displacement) mod 2^16.
- R7: With `mode`=11 (counter-relative), the cycle after an accepted `start` has `done`=1 and `ea` = (`ic_val` + sign-extended displacement) mod 2^16, where displacement bit 8 is the sign.
- R8: A `start` that arrives while `mem_req` is 1 is dropped. It produces no `done` and leaves `mem_addr` unchanged, and it is not carried out later.
- R9: `done` rises only in the cycle after an accepted `start` or an acknowledged read. Otherwise it is 0, and `ea` keeps its last value.
- R10: A `mem_ack` while no read is outstanding has no effect: `done` and `mem_req` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address calculation |
| mode | input | 2 | 00 absolute, 01 pointer, 10 index-based, 11 counter-relative |
| disp | input | 9 | Displacement field of the instruction |
| use_ext | input | 1 | In absolute mode, take the second instruction word |
| ext_word | input | 16 | Second instruction word |
| idx_val | input | 16 | Index register contents |
| ic_val | input | 16 | Instruction counter (next-instruction address) |
| mem_req | output | 1 | Pointer read request, held until acknowledged |
| mem_addr | output | 16 | Pointer location being read |
| mem_ack | input | 1 | Memory acknowledge; `mem_rdata` valid with it |
| mem_rdata | input | 16 | Word read from memory |
| ea | output | 16 | Effective operand address |
| done | output | 1 | One-cycle pulse: `ea` is valid |

## Verification
The hardest situation to reach is a pointer read that is still waiting while the port sees more activity: a fresh `start` in either the pointer or the absolute mode, or an acknowledge while nothing is outstanding. The stimulus drives all 512 displacements through the pointer mode and holds the acknowledge back for zero to three cycles, chosen from the displacement. In the first waiting cycle it injects a conflicting `start` with a different displacement. It then checks that the request address does not move, that no extra `done` appears, and that nothing fires after the real completion. The arithmetic modes are swept over every displacement, with index and counter values placed so that results wrap past 0xFFFF and negative offsets cross zero.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  typedef enum logic [1:0] {
    AM_ABS    = 2'b00,
    AM_PTR    = 2'b01,
    AM_INDEX  = 2'b10,
    AM_REL    = 2'b11
  } amode_e;

endpackage

// File: rtl/opaddr_base_sel.sv
// Combinational address arithmetic: one shared adder for the index-based and
// counter-relative modes, and a separate constant-offset add for the pointer location.
module opaddr_base_sel
  import opaddr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DISP_W   = 9,
  parameter int PTR_BASE = 512
) (
  input  amode_e            mode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              use_ext_i,
  input  logic [ADDR_W-1:0] ext_word_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [ADDR_W-1:0] ic_i,
  output logic [ADDR_W-1:0] calc_addr_o,
  output logic [ADDR_W-1:0] ptr_addr_o
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_z;
  logic [ADDR_W-1:0] disp_s;
  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] off_sel;

  // Widening of the displacement; a generate picks the form when the widths match.
  generate
    if (EXT_W > 0) begin : g_widen
      assign disp_z = {{EXT_W{1'b0}}, disp_i};
      assign disp_s = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_same
      assign disp_z = disp_i[ADDR_W-1:0];
      assign disp_s = disp_i[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    base_sel = '0;
    off_sel  = disp_z;
    unique case (mode_i)
      AM_INDEX: base_sel = idx_i;
      AM_REL: begin
        base_sel = ic_i;
        off_sel  = disp_s;
      end
      default: base_sel = '0;
    endcase
  end

  always_comb begin
    if (mode_i == AM_ABS && use_ext_i) calc_addr_o = ext_word_i;
    else                               calc_addr_o = base_sel + off_sel;
  end

  assign ptr_addr_o = disp_z + ADDR_W'(PTR_BASE);

endmodule

// File: rtl/opaddr_ptr_fetch.sv
// Single outstanding pointer read. The request register is also the busy state.
module opaddr_ptr_fetch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] launch_addr_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              fetch_done_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
    end else if (!mem_req_o && launch_i) begin
      mem_req_o  <= 1'b1;
      mem_addr_o <= launch_addr_i;
    end else if (mem_req_o && mem_ack_i) begin
      mem_req_o  <= 1'b0;
    end
  end

  assign fetch_done_o = mem_req_o && mem_ack_i;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R8
  no_relaunch_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && launch_i) |=> $stable(mem_addr_o));

endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
  import opaddr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DISP_W   = 9,
  parameter int PTR_BASE = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic              use_ext,
  input  logic [ADDR_W-1:0] ext_word,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [ADDR_W-1:0] ic_val,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] ea,
  output logic              done
);

  amode_e            mode_e;
  logic [ADDR_W-1:0] calc_addr;
  logic [ADDR_W-1:0] ptr_addr;
  logic              accept;
  logic              launch;
  logic              fetch_done;

  assign mode_e = amode_e'(mode);
  assign accept = start && !mem_req;
  assign launch = accept && (mode_e == AM_PTR);

  opaddr_base_sel #(
    .ADDR_W  (ADDR_W),
    .DISP_W  (DISP_W),
    .PTR_BASE(PTR_BASE)
  ) u_base_sel (
    .mode_i     (mode_e),
    .disp_i     (disp),
    .use_ext_i  (use_ext),
    .ext_word_i (ext_word),
    .idx_i      (idx_val),
    .ic_i       (ic_val),
    .calc_addr_o(calc_addr),
    .ptr_addr_o (ptr_addr)
  );

  opaddr_ptr_fetch #(
    .ADDR_W(ADDR_W)
  ) u_ptr_fetch (
    .clk          (clk),
    .rst          (rst),
    .launch_i     (launch),
    .launch_addr_i(ptr_addr),
    .mem_ack_i    (mem_ack),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .fetch_done_o (fetch_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      ea   <= '0;
    end else begin
      done <= 1'b0;
      if (accept && mode_e != AM_PTR) begin
        done <= 1'b1;
        ea   <= calc_addr;
      end else if (fetch_done) begin
        done <= 1'b1;
        ea   <= mem_rdata;
      end
    end
  end

  // R2
  abs_short_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode == 2'b00 && !use_ext)
      |=> (done && ea == ADDR_W'($past(disp))));

  // R3
  abs_long_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode == 2'b00 && use_ext)
      |=> (done && ea == $past(ext_word)));

  // R4
  ptr_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && mode == 2'b01)
      |=> (mem_req && !done && mem_addr == ADDR_W'($past(disp)) + ADDR_W'(PTR_BASE)));

  // R5
  ptr_return_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (done && !mem_req && ea == $past(mem_rdata)));

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> !done);

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(start && !mem_req && mode != 2'b01) || $past(mem_req && mem_ack)));

  // R9
  ea_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ea));

  // R10
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_req && mem_ack && !start) |=> (!done && !mem_req));

endmodule

// File: tb/operand_addr_gen_tb.sv
module operand_addr_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [1:0]  mode;
  logic [8:0]  disp;
  logic        use_ext;
  logic [15:0] ext_word;
  logic [15:0] idx_val;
  logic [15:0] ic_val;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic [15:0] ea;
  logic        done;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_addr_gen u_dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode     (mode),
    .disp     (disp),
    .use_ext  (use_ext),
    .ext_word (ext_word),
    .idx_val  (idx_val),
    .ic_val   (ic_val),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .ea       (ea),
    .done     (done)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One arithmetic-mode calculation; results are sampled on the following negedge.
  task automatic run_calc(input logic [1:0] m, input logic [8:0] d, input logic ue,
                          input logic [15:0] xw, input logic [15:0] iv, input logic [15:0] cv,
                          input logic [15:0] exp, input string tag);
    @(negedge clk);
    start = 1'b1; mode = m; disp = d; use_ext = ue;
    ext_word = xw; idx_val = iv; ic_val = cv;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check({tag, " done"}, {15'd0, done}, 16'd1);
    check({tag, " ea"}, ea, exp);
  endtask

  // One pointer-mode calculation with a given acknowledge delay and a stray start.
  task automatic run_ptr(input logic [8:0] d, input int wait_cyc,
                         input logic [1:0] stray_mode, input logic [15:0] rv);
    logic [15:0] exp_addr;
    exp_addr = {7'd0, d} + 16'd512;
    @(negedge clk);
    start = 1'b1; mode = 2'b01; disp = d; use_ext = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R4 req", {15'd0, mem_req}, 16'd1);
    check("R4 addr", mem_addr, exp_addr);
    check("R4 no done", {15'd0, done}, 16'd0);
    for (int i = 0; i < wait_cyc; i++) begin
      if (i == 0) begin
        start = 1'b1; mode = stray_mode; disp = ~d;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R8 no done", {15'd0, done}, 16'd0);
      check("R4 req held", {15'd0, mem_req}, 16'd1);
      check("R8 addr held", mem_addr, exp_addr);
    end
    mem_ack = 1'b1; mem_rdata = rv;
    @(posedge clk);
    @(negedge clk);
    mem_ack = 1'b0; mem_rdata = 16'hDEAD;
    check("R5 done", {15'd0, done}, 16'd1);
    check("R5 ea", ea, rv);
    check("R5 req low", {15'd0, mem_req}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    check("R9 single pulse", {15'd0, done}, 16'd0);
    check("R9 ea hold", ea, rv);
    check("R8 no late fetch", {15'd0, mem_req}, 16'd0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] idx_set [4];
    logic [15:0] ic_set  [4];
    logic [15:0] ext_set [4];
    idx_set = '{16'h0000, 16'h1234, 16'hFF00, 16'hFFFF};
    ic_set  = '{16'h0000, 16'h0005, 16'h8000, 16'hFFF0};
    ext_set = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h0200};

    rst = 1'b1; start = 1'b0; mode = 2'b00; disp = '0; use_ext = 1'b0;
    ext_word = '0; idx_val = '0; ic_val = '0; mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    check("R1 done", {15'd0, done}, 16'd0);
    check("R1 req", {15'd0, mem_req}, 16'd0);
    check("R1 addr", mem_addr, 16'd0);
    check("R1 ea", ea, 16'd0);

    // R2: every displacement in absolute mode
    for (int d = 0; d < 512; d++)
      run_calc(2'b00, 9'(d), 1'b0, 16'hBEEF, 16'h4444, 16'h5555, 16'(d), "R2");

    // R3: second word overrides the displacement
    for (int k = 0; k < 4; k++)
      for (int d = 0; d < 512; d += 73)
        run_calc(2'b00, 9'(d), 1'b1, ext_set[k], 16'h4444, 16'h5555, ext_set[k], "R3");

    // R6: index plus zero-extended displacement, with wrap
    for (int k = 0; k < 4; k++)
      for (int d = 0; d < 512; d++)
        run_calc(2'b10, 9'(d), 1'b0, 16'h0, idx_set[k], 16'h7777,
                 16'(int'(idx_set[k]) + d), "R6");

    // R7: counter plus sign-extended displacement
    for (int k = 0; k < 4; k++)
      for (int d = 0; d < 512; d++) begin
        int sd;
        sd = (d >= 256) ? d - 512 : d;
        run_calc(2'b11, 9'(d), 1'b0, 16'h0, 16'h3333, ic_set[k],
                 16'(int'(ic_set[k]) + sd), "R7");
      end

    // R10: acknowledge with nothing outstanding
    @(negedge clk);
    mem_ack = 1'b1; mem_rdata = 16'h1111;
    @(posedge clk);
    @(negedge clk);
    mem_ack = 1'b0;
    check("R10 done", {15'd0, done}, 16'd0);
    check("R10 req", {15'd0, mem_req}, 16'd0);
    check("R10 ea", ea, 16'(int'(ic_set[3]) - 1));

    // R4 R5 R8 R9: pointer mode over every displacement
    for (int d = 0; d < 512; d++)
      run_ptr(9'(d), d % 4, (d % 2 == 1) ? 2'b00 : 2'b01, 16'(d * 37 + 1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule